// File: doc/BRIEF.md
# Watchdog Timer with Selectable Count Unit

This block is a system watchdog built around a 16-bit down-counter. The counter is decremented either once per second or once per minute. A one-per-second tick-enable input drives it. In minute mode a divide-by-60 prescaler sits between that tick and the counter.

Software controls the block through four byte-wide registers, addressed over a narrow write port:

- a control register, which holds the reload-source enables, a force bit and the expiry status bit;
- a configuration register, which holds the unit select, the output-pulse enables and an interrupt-select field;
- two count bytes.

Writing a count byte loads the combined 16-bit value. A nonzero value starts or restarts the timer, and a value of zero stops it.

When the count runs out, the block sets a sticky status bit and stops the counter. It can also emit a keyboard-reset pulse and a power-OK pulse of fixed length. While the timer runs, selected peripheral events reload it with the programmed value. A game-port read, a keyboard interrupt or a mouse interrupt reloads it at once. A consumer-IR interrupt reloads it only after a fixed delay. Decoding the configuration bus and the peripherals that raise the events belong to the surrounding logic.

Top module: `wdog_unit_timer`

## Requirements
- R1: After reset the count is 0, the timer is stopped, both pulse outputs are low, and every register reads back 0.
- R2: Register select codes are 0 for control, 1 for configuration, 2 for the count low byte and 3 for the count high byte. A write to either count byte loads the counter with {high, low}, using the new byte and the held other byte. A nonzero value starts the timer, and a zero value stops it with the count at 0.
- R3: With configuration bit 7 set (seconds), a running counter decrements by one on each cycle in which the tick input is high, and holds on all other cycles.
- R4: With configuration bit 7 clear (minutes), a running counter decrements once per 60 ticks. The prescaler restarts from zero on every load and every reload.
- R5: When the count steps from 1 to 0, the timer stops and control bit 0 (status) is set. Further ticks leave the count at 0 until a count byte is rewritten.
- R6: The status bit stays set until a control write with data bit 0 equal to 0. A control write with data bit 0 equal to 1 leaves it set.
- R7: On expiry, the keyboard-reset output (configuration bit 6 set) and the power-OK output (configuration bit 4 set) go high from the next cycle for exactly PULSE_CYC cycles. An output whose enable bit is clear stays low.
- R8: While the timer runs, a game-port read (control bit 4), a keyboard interrupt (bit 5) or a mouse interrupt (bit 6) reloads the programmed count on the next clock edge. A disabled event, or any event while the timer is stopped, has no effect.
- R9: With control bit 7 set, a consumer-IR event reloads the programmed count exactly CIR_DELAY cycles later. Further consumer-IR events during the wait are ignored. With bit 7 clear, the event has no effect.
- R10: A control write with data bit 1 set forces an immediate expiry: the count becomes 0, the timer stops, status is set and the enabled pulses fire. Control bit 1 always reads back 0.
- R11: Reading returns, by select code, control as {enables[7:4], 2'b00, 1'b0, status}, the full configuration byte, or the programmed count bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle enable, once per second |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 config, 2 count low, 3 count high) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| ev_gp_read | input | 1 | Game-port read event |
| ev_kbd_irq | input | 1 | Keyboard interrupt event |
| ev_mouse_irq | input | 1 | Mouse interrupt event |
| ev_cir_irq | input | 1 | Consumer-IR interrupt event |
| count_now | output | 16 | Current counter value |
| running | output | 1 | Timer running |
| kbd_rst_pulse | output | 1 | Keyboard-reset pulse on expiry |
| pwr_ok_pulse | output | 1 | Power-OK pulse on expiry |

## Verification
The delayed consumer-IR reload is the hardest case to observe, because a reload to an unchanged count is invisible. The stimulus first ticks the counter below its programmed value. It then raises the event, raises a second event partway through the wait, and samples the count one cycle before and at the reload cycle. The prescaler reset is exposed the same way: a reload in the middle of a minute must push the next decrement out by a full 60 ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_CFG    = 2'd1,
    SEL_CNT_LO = 2'd2,
    SEL_CNT_HI = 2'd3
  } wdt_sel_e;

  // control register bit positions
  localparam int CT_STS   = 0;
  localparam int CT_FORCE = 1;
  localparam int CT_GP    = 4;
  localparam int CT_KBD   = 5;
  localparam int CT_MOUSE = 6;
  localparam int CT_CIR   = 7;

  // configuration register bit positions
  localparam int CF_PWROK = 4;
  localparam int CF_KRST  = 6;
  localparam int CF_SEC   = 7;
endpackage

// File: rtl/wdt_unit_presc.sv
module wdt_unit_presc #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sec_mode,
  input  logic clr,
  input  logic tick_1s,
  output logic unit_tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] presc_q, presc_d;

  always_comb begin
    presc_d   = presc_q;
    unit_tick = 1'b0;
    if (!run || clr) begin
      presc_d = '0;
    end else if (tick_1s) begin
      if (sec_mode) begin
        unit_tick = 1'b1;
        presc_d   = '0;
      end else if (presc_q == PW'(DIV - 1)) begin
        unit_tick = 1'b1;
        presc_d   = '0;
      end else begin
        presc_d = presc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  // R4: prescaler never leaves its range
  a_r4_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= PW'(DIV - 1));
  // R4: a load or reload restarts the prescaler
  a_r4_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> presc_q == '0);
endmodule

// File: rtl/wdt_reload_ctl.sv
module wdt_reload_ctl #(
  parameter int DLY = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ev_gp,
  input  logic ev_kbd,
  input  logic ev_mouse,
  input  logic ev_cir,
  input  logic en_gp,
  input  logic en_kbd,
  input  logic en_mouse,
  input  logic en_cir,
  output logic reload
);
  localparam int DW = $clog2(DLY + 1);

  logic          pend_q, pend_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          fast_hit, slow_hit;

  always_comb begin
    fast_hit = run && ((ev_gp && en_gp) || (ev_kbd && en_kbd) || (ev_mouse && en_mouse));
    slow_hit = run && pend_q && (dcnt_q == '0);
    pend_d   = pend_q;
    dcnt_d   = dcnt_q;
    if (!run) begin
      pend_d = 1'b0;
      dcnt_d = '0;
    end else if (pend_q) begin
      if (dcnt_q == '0) pend_d = 1'b0;
      else              dcnt_d = dcnt_q - 1'b1;
    end else if (ev_cir && en_cir) begin
      pend_d = 1'b1;
      dcnt_d = DW'(DLY - 1);
    end
    reload = fast_hit || slow_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      dcnt_q <= dcnt_d;
    end
  end

  // R9: wait counter stays inside the programmed delay
  a_r9_delay_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> dcnt_q <= DW'(DLY - 1));
  // R9: a pending delayed reload is dropped once the timer stops
  a_r9_drop_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pend_q);
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         force_exp,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         reload,
  input  logic [W-1:0] reload_val,
  input  logic         unit_tick,
  output logic [W-1:0] cnt,
  output logic         run,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    expire = 1'b0;
    if (force_exp) begin
      cnt_d  = '0;
      run_d  = 1'b0;
      expire = 1'b1;
    end else if (load) begin
      cnt_d = load_val;
      run_d = (load_val != '0);
    end else if (run_q && reload) begin
      cnt_d = reload_val;
    end else if (run_q && unit_tick) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == W'(1)) begin
        run_d  = 1'b0;
        expire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt = cnt_q;
  assign run = run_q;

  // R5: a running timer never holds a zero count
  a_r5_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q != '0);
  // R5: expiry leaves the timer stopped at zero
  a_r5_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!run_q && cnt_q == '0));
  // R3: an undisturbed unit tick takes exactly one off the count
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && unit_tick && !load && !reload && !force_exp) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R5: a stopped timer holds its count until loaded
  a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load && !force_exp) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic en_kbd,
  input  logic en_pwr,
  output logic kbd_pulse,
  output logic pwr_pulse
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          kbd_q, kbd_d, pwr_q, pwr_d;

  always_comb begin
    cnt_d = cnt_q;
    kbd_d = kbd_q;
    pwr_d = pwr_q;
    if (start) begin
      cnt_d = CW'(CYC - 1);
      kbd_d = en_kbd;
      pwr_d = en_pwr;
    end else if (kbd_q || pwr_q) begin
      if (cnt_q == '0) begin
        kbd_d = 1'b0;
        pwr_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      kbd_q <= 1'b0;
      pwr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      kbd_q <= kbd_d;
      pwr_q <= pwr_d;
    end
  end

  assign kbd_pulse = kbd_q;
  assign pwr_pulse = pwr_q;

  // R7: no pulse appears without an expiry
  a_r7_kbd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !kbd_q) |=> !kbd_q);
  a_r7_pwr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !pwr_q) |=> !pwr_q);
  // R7: a disabled output stays low on expiry
  a_r7_kbd_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !en_kbd) |=> !kbd_q);
endmodule

// File: rtl/wdog_unit_timer.sv
module wdog_unit_timer #(
  parameter int PRESC_DIV = 60,
  parameter int PULSE_CYC = 1000,
  parameter int CIR_DELAY = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1s,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        ev_gp_read,
  input  logic        ev_kbd_irq,
  input  logic        ev_mouse_irq,
  input  logic        ev_cir_irq,
  output logic [15:0] count_now,
  output logic        running,
  output logic        kbd_rst_pulse,
  output logic        pwr_ok_pulse
);
  import wdt_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  // register state
  logic [3:0]       en_q, en_d;
  logic             sts_q, sts_d;
  logic [7:0]       cfg_q, cfg_d;
  logic [7:0]       lo_q, lo_d, hi_q, hi_d;
  logic             wr_ctrl, wr_cfg, wr_lo, wr_hi;
  logic             force_exp, load, reload, unit_tick, expire;
  logic [CNT_W-1:0] load_val, prog_val, cnt;
  logic             run;

  always_comb begin
    wr_ctrl   = reg_we && (reg_sel == SEL_CTRL);
    wr_cfg    = reg_we && (reg_sel == SEL_CFG);
    wr_lo     = reg_we && (reg_sel == SEL_CNT_LO);
    wr_hi     = reg_we && (reg_sel == SEL_CNT_HI);
    force_exp = wr_ctrl && reg_wdata[CT_FORCE];
    load      = wr_lo || wr_hi;
    load_val  = wr_lo ? {hi_q, reg_wdata} : {reg_wdata, lo_q};
    prog_val  = {hi_q, lo_q};

    en_d  = wr_ctrl ? reg_wdata[7:4] : en_q;
    cfg_d = wr_cfg  ? reg_wdata      : cfg_q;
    lo_d  = wr_lo   ? reg_wdata      : lo_q;
    hi_d  = wr_hi   ? reg_wdata      : hi_q;

    sts_d = sts_q;
    if (wr_ctrl && !reg_wdata[CT_STS]) sts_d = 1'b0;
    if (expire)                        sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q  <= '0;
      sts_q <= 1'b0;
      cfg_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
      cfg_q <= cfg_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL:   reg_rdata = {en_q, 2'b00, 1'b0, sts_q};
      SEL_CFG:    reg_rdata = cfg_q;
      SEL_CNT_LO: reg_rdata = lo_q;
      default:    reg_rdata = hi_q;
    endcase
  end

  wdt_unit_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk       (clk),
    .rst_n     (rst_ns),
    .run       (run),
    .sec_mode  (cfg_q[CF_SEC]),
    .clr       (load || reload),
    .tick_1s   (tick_1s),
    .unit_tick (unit_tick)
  );

  wdt_reload_ctl #(.DLY(CIR_DELAY)) u_reload (
    .clk      (clk),
    .rst_n    (rst_ns),
    .run      (run),
    .ev_gp    (ev_gp_read),
    .ev_kbd   (ev_kbd_irq),
    .ev_mouse (ev_mouse_irq),
    .ev_cir   (ev_cir_irq),
    .en_gp    (en_q[CT_GP-4]),
    .en_kbd   (en_q[CT_KBD-4]),
    .en_mouse (en_q[CT_MOUSE-4]),
    .en_cir   (en_q[CT_CIR-4]),
    .reload   (reload)
  );

  wdt_down_cnt #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_ns),
    .force_exp  (force_exp),
    .load       (load),
    .load_val   (load_val),
    .reload     (reload),
    .reload_val (prog_val),
    .unit_tick  (unit_tick),
    .cnt        (cnt),
    .run        (run),
    .expire     (expire)
  );

  wdt_pulse_gen #(.CYC(PULSE_CYC)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_ns),
    .start     (expire),
    .en_kbd    (cfg_q[CF_KRST]),
    .en_pwr    (cfg_q[CF_PWROK]),
    .kbd_pulse (kbd_rst_pulse),
    .pwr_pulse (pwr_ok_pulse)
  );

  assign count_now = cnt;
  assign running   = run;

  // R6: status holds unless a control write clears bit 0
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_ns)
    (sts_q && !(wr_ctrl && !reg_wdata[CT_STS])) |=> sts_q);
  // R10: a force write expires the timer at once
  a_r10_force_expires: assert property (@(posedge clk) disable iff (!rst_ns)
    force_exp |=> (sts_q && !running && count_now == '0));
  // R2: a zero load leaves the timer stopped
  a_r2_zero_stops: assert property (@(posedge clk) disable iff (!rst_ns)
    (load && load_val == '0) |=> !running);
endmodule

// File: tb/tb_wdog_unit_timer.sv
module tb_wdog_unit_timer;
  localparam int PC = 4;
  localparam int CD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1s = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        ev_gp_read = 1'b0, ev_kbd_irq = 1'b0, ev_mouse_irq = 1'b0, ev_cir_irq = 1'b0;
  logic [15:0] count_now;
  logic        running, kbd_rst_pulse, pwr_ok_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_unit_timer #(.PRESC_DIV(60), .PULSE_CYC(PC), .CIR_DELAY(CD)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_gp_read(ev_gp_read), .ev_kbd_irq(ev_kbd_irq), .ev_mouse_irq(ev_mouse_irq),
    .ev_cir_irq(ev_cir_irq), .count_now(count_now), .running(running),
    .kbd_rst_pulse(kbd_rst_pulse), .pwr_ok_pulse(pwr_ok_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] data);
    reg_sel = sel;
    #1 data = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1s = 1'b1;
      @(negedge clk);
      tick_1s = 1'b0;
    end
  endtask

  task automatic ev(input int which);
    case (which)
      0: ev_gp_read = 1'b1;
      1: ev_kbd_irq = 1'b1;
      2: ev_mouse_irq = 1'b1;
      default: ev_cir_irq = 1'b1;
    endcase
    @(negedge clk);
    ev_gp_read = 1'b0; ev_kbd_irq = 1'b0; ev_mouse_irq = 1'b0; ev_cir_irq = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 count", count_now, 0);
    chk("R1 running", running, 0);
    chk("R1 pulses", {kbd_rst_pulse, pwr_ok_pulse}, 0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk("R1 readback", d, 0);
    end
  endtask

  task automatic t_seconds_load;
    wr(2'd1, 8'h80);
    wr(2'd2, 8'd5);
    chk("R2 load low", count_now, 5);
    chk("R2 running", running, 1);
    ticks(2);
    chk("R3 two ticks", count_now, 3);
    idle(5);
    chk("R3 hold without tick", count_now, 3);
    wr(2'd3, 8'h01);
    chk("R2 load high", count_now, 16'h0105);
    wr(2'd2, 8'h00);
    chk("R2 low zero, high kept", count_now, 16'h0100);
    wr(2'd3, 8'h00);
    chk("R2 zero stops", running, 0);
    ticks(2);
    chk("R2 stopped holds", count_now, 0);
  endtask

  task automatic t_expiry;
    logic [7:0] d;
    wr(2'd1, 8'hD0);
    wr(2'd2, 8'd2);
    ticks(1);
    chk("R3 step", count_now, 1);
    chk("R7 no pulse before expiry", {kbd_rst_pulse, pwr_ok_pulse}, 0);
    ticks(1);
    chk("R5 count zero", count_now, 0);
    chk("R5 stopped", running, 0);
    rd(2'd0, d);
    chk("R5 status set", d[0], 1);
    chk("R7 both pulses high", {kbd_rst_pulse, pwr_ok_pulse}, 2'b11);
    idle(PC - 1);
    chk("R7 pulse last cycle", {kbd_rst_pulse, pwr_ok_pulse}, 2'b11);
    idle(1);
    chk("R7 pulse ended", {kbd_rst_pulse, pwr_ok_pulse}, 2'b00);
    ticks(3);
    chk("R5 no restart", count_now, 0);
    wr(2'd0, 8'h01);
    rd(2'd0, d);
    chk("R6 write one keeps status", d[0], 1);
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    chk("R6 write zero clears", d[0], 0);
  endtask

  task automatic t_pulse_disabled;
    logic [7:0] d;
    wr(2'd1, 8'h80);
    wr(2'd2, 8'd1);
    ticks(1);
    rd(2'd0, d);
    chk("R5 status on expiry", d[0], 1);
    chk("R7 disabled pulses low", {kbd_rst_pulse, pwr_ok_pulse}, 0);
    idle(2);
    chk("R7 disabled pulses stay low", {kbd_rst_pulse, pwr_ok_pulse}, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_minutes;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd2);
    ticks(59);
    chk("R4 59 ticks no step", count_now, 2);
    ticks(1);
    chk("R4 60th tick steps", count_now, 1);
    wr(2'd0, 8'h10);
    wr(2'd2, 8'd3);
    ticks(30);
    chk("R4 mid minute", count_now, 3);
    ev(0);
    chk("R8 gp reload", count_now, 3);
    ticks(59);
    chk("R4 prescaler restarted on reload", count_now, 3);
    ticks(1);
    chk("R4 full minute after reload", count_now, 2);
  endtask

  task automatic t_reload_sources;
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'd9);
    ticks(4);
    chk("R3 four ticks", count_now, 5);
    ev(0);
    chk("R8 gp disabled ignored", count_now, 5);
    ev(1);
    chk("R8 kbd disabled ignored", count_now, 5);
    wr(2'd0, 8'h60);
    ev(1);
    chk("R8 kbd reload", count_now, 9);
    ticks(2);
    ev(2);
    chk("R8 mouse reload", count_now, 9);
    wr(2'd2, 8'd0);
    ev(1);
    chk("R8 stopped ignores event", {15'd0, running, count_now}, 0);
  endtask

  task automatic t_cir;
    wr(2'd0, 8'h80);
    wr(2'd2, 8'd6);
    ticks(2);
    chk("R3 before cir", count_now, 4);
    ev(3);
    idle(3);
    ev(3);
    idle(CD - 5);
    chk("R9 not yet reloaded", count_now, 4);
    idle(1);
    chk("R9 reload after delay", count_now, 6);
    ticks(1);
    idle(3);
    chk("R9 second event ignored", count_now, 5);
    wr(2'd0, 8'h00);
    ev(3);
    idle(CD + 2);
    chk("R9 disabled cir ignored", count_now, 5);
  endtask

  task automatic t_force_readback;
    logic [7:0] d;
    wr(2'd1, 8'h90);
    wr(2'd2, 8'd7);
    wr(2'd0, 8'h02);
    chk("R10 force count", {15'd0, running, count_now}, 0);
    chk("R10 force pulses", {kbd_rst_pulse, pwr_ok_pulse}, 2'b01);
    rd(2'd0, d);
    chk("R10 force bit reads 0, status set", d, 8'h01);
    wr(2'd0, 8'hF0);
    rd(2'd0, d);
    chk("R11 control readback", d, 8'hF0);
    wr(2'd1, 8'hA5);
    rd(2'd1, d);
    chk("R11 config readback", d, 8'hA5);
    wr(2'd3, 8'h3C);
    rd(2'd3, d);
    chk("R11 high readback", d, 8'h3C);
    rd(2'd2, d);
    chk("R11 low readback", d, 8'h07);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_seconds_load();
    t_expiry();
    t_pulse_disabled();
    t_minutes();
    t_reload_sources();
    t_cir();
    t_force_readback();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule